// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-facing register file of an interrupt redirection controller. A bus master sees only two 32-bit locations: a select register at offset 0x00 and a data window at offset 0x10. The value held in the select register decides which internal register the window reaches. The internal registers are a 4-bit identification register, a read-only version word, and a table with one 64-bit redirection entry per input pin. Each entry is reached as two 32-bit halves.

Writes through the window update the table. Each table write also tells the neighbouring interrupt engine about two things. It pulses a mask-change notification when the entry's mask bit flips. It pulses a service request when the written entry is level-triggered and the pin's request bit is set. The engine reads every entry through a flat output bus. It sets an entry's remote-IRR status bit through a per-pin strobe. The bus accepts every access in the cycle it is presented. Read data returns one cycle later.

Top module: `irq_redir_regs`

## Requirements
- R1: Writing offset 0x00 stores the low byte of the (lane-masked) write data in the 8-bit select register, and reading offset 0x00 returns it zero-extended.
- R2: A select value of 0x10 or above reaches table entry (select − 0x10) >> 1; select bit 0 = 1 reaches entry bits 63:32, bit 0 = 0 reaches bits 31:0.
- R3: With select 0x01 the window reads {8'h00, NPINS−1, 8'h00, VERSION} (0x00170011 by default); writes there change nothing.
- R4: With select 0x00 the window holds the ID in bits 27:24 and writes set it; select 0x02 reads the same word, but writes there are ignored.
- R5: A low-half write replaces bits 31:0 and clears remote-IRR (bit 14) regardless of the data; a high-half write replaces only bits 63:32.
- R6: A table write whose entry index is NPINS or above is dropped, and a read there returns 0.
- R7: One cycle after a table write that flips the mask bit (bit 16), mask_chg_valid pulses for one cycle with the pin index and the new mask value; otherwise it stays low.
- R8: One cycle after a table write that leaves the entry level-triggered (bit 15 = 1) while pin_req of that pin is 1, svc_valid pulses with the pin index; otherwise it stays low.
- R9: After reset the select register and ID are zero, every entry reads 0x00010000 (low) / 0x00000000 (high), and no pulse or read response is pending.
- R10: Only offsets 0x00 and 0x10 are registers; an offset with any of bits 3:0 set, or any other offset, reads 0 and ignores writes.
- R11: Write data is masked per byte lane by bus_be (bit n enables bits 8n+7:8n); disabled lanes are written as zero, and an all-zero bus_be writes nothing.
- R12: A rirr_set strobe sets remote-IRR of that pin's entry; a low-half write in the same cycle takes precedence and clears it.
- R13: bus_ready is always 1; a read accepted in one cycle has bus_rvalid high with its data in the next cycle, and writes never raise bus_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Access accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the register region |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| pin_req | input | NPINS | Request bit per pin from the engine |
| rirr_set | input | NPINS | Set remote-IRR per pin |
| tbl_flat | output | NPINS*64 | All entries, entry i at bits 64i+63:64i |
| mask_chg_valid | output | 1 | Mask-change pulse |
| mask_chg_pin | output | $clog2(NPINS) | Pin whose mask changed |
| mask_chg_value | output | 1 | New mask value |
| svc_valid | output | 1 | Service request pulse |
| svc_pin | output | $clog2(NPINS) | Pin to service |

## Verification
The hardest situation to reach is the interaction of a table write with state that software cannot write directly. Examples are a low-half write clearing a remote-IRR bit that only the engine can set, and a service request caused by a high-half write that leaves an earlier level-trigger setting in place. The stimulus first programs an entry, then sets remote-IRR through the strobe, and then writes each half in turn. It toggles pin_req between writes so that the same entry is seen with and without a pending request. Narrow byte enables are used to move the mask bit by way of zero-extension.

// File: rtl/irq_redir_pkg.sv
// Shared definitions for the redirection register window.
// Holds the entry field positions that the interrupt engine also decodes,
// the two bus offsets, and the classification of the select value.
package irq_redir_pkg;

    localparam logic [7:0] OFF_SELECT = 8'h00;
    localparam logic [7:0] OFF_WINDOW = 8'h10;
    localparam logic [7:0] SEL_TABLE0 = 8'h10;

    localparam int F_RIRR = 14;
    localparam int F_TRIG = 15;
    localparam int F_MASK = 16;

    localparam logic [63:0] ENTRY_RST = 64'(1) << F_MASK;

    typedef enum logic [2:0] {
        KIND_ID,
        KIND_VER,
        KIND_ARB,
        KIND_TBL,
        KIND_NONE
    } sel_kind_e;

endpackage

// File: rtl/irq_redir_decode.sv
// Select decoder: classifies the 8-bit select value and, for table
// selects, derives the entry index, its validity and the half.
// Assumes NPINS fits in the 7-bit index range a select can reach.
module irq_redir_decode
    import irq_redir_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int PIN_W = $clog2(NPINS)
) (
    input  logic [7:0]       sel,
    output sel_kind_e        kind,
    output logic             idx_ok,
    output logic [PIN_W-1:0] pin,
    output logic             hi
);
    localparam logic [6:0] NPINS_7 = 7'(NPINS);

    logic [7:0] rel;
    logic [6:0] idx;

    // Offset of the select within the table region, split into index and half.
    always_comb begin
        rel = sel - SEL_TABLE0;
        idx = rel[7:1];
        hi  = rel[0];
        pin = idx[PIN_W-1:0];
    end

    // Classify the select value and check the index against the pin count.
    always_comb begin
        idx_ok = 1'b0;
        if (sel >= SEL_TABLE0) begin
            kind   = KIND_TBL;
            idx_ok = (idx < NPINS_7);
        end else if (sel == 8'h00) begin
            kind = KIND_ID;
        end else if (sel == 8'h01) begin
            kind = KIND_VER;
        end else if (sel == 8'h02) begin
            kind = KIND_ARB;
        end else begin
            kind = KIND_NONE;
        end
    end

endmodule

// File: rtl/irq_redir_entry.sv
// One 64-bit redirection entry with split-half write access.
// A low-half write clears remote-IRR and overrides a set strobe arriving in
// the same cycle. Reset leaves the entry masked.
module irq_redir_entry
    import irq_redir_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    output logic [63:0] q
);
    // Entry storage: half writes, remote-IRR set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= ENTRY_RST;
        end else begin
            if (wr_lo) begin
                q[31:0]   <= wdata;
                q[F_RIRR] <= 1'b0;
            end else if (rirr_set) begin
                q[F_RIRR] <= 1'b1;
            end
            if (wr_hi) begin
                q[63:32] <= wdata;
            end
        end
    end

endmodule

// File: rtl/irq_redir_regs.sv
// Indirect register window of an interrupt redirection controller.
// The bus reaches a select register (offset 0x00) and a data window
// (offset 0x10). Every access is accepted at once, and reads answer one
// cycle later. Table writes raise mask-change and service pulses one cycle
// later. Only 16-byte-aligned offsets decode.
module irq_redir_regs
    import irq_redir_pkg::*;
#(
    parameter int          NPINS   = 24,
    parameter logic [7:0]  VERSION = 8'h11,
    localparam int         PIN_W   = $clog2(NPINS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    output logic                  bus_ready,
    input  logic                  bus_write,
    input  logic [7:0]            bus_addr,
    input  logic [3:0]            bus_be,
    input  logic [31:0]           bus_wdata,
    output logic                  bus_rvalid,
    output logic [31:0]           bus_rdata,
    input  logic [NPINS-1:0]      pin_req,
    input  logic [NPINS-1:0]      rirr_set,
    output logic [NPINS*64-1:0]   tbl_flat,
    output logic                  mask_chg_valid,
    output logic [PIN_W-1:0]      mask_chg_pin,
    output logic                  mask_chg_value,
    output logic                  svc_valid,
    output logic [PIN_W-1:0]      svc_pin
);
    localparam logic [7:0] PIN_MAX = 8'(NPINS - 1);

    logic [7:0]       sel_q;
    logic [3:0]       id_q;
    logic [31:0]      wd;
    logic             wr_any;
    logic             hit_sel;
    logic             hit_win;
    logic             win_wr;
    logic             tbl_wr;
    sel_kind_e        kind;
    logic             idx_ok;
    logic [PIN_W-1:0] pin;
    logic             hi;
    logic [63:0]      ent_q [NPINS];
    logic [63:0]      cur;
    logic             new_mask;
    logic             new_trig;
    logic [31:0]      rd_next;

    assign bus_ready = 1'b1;

    // Lane masking (zero-extension of narrow writes) and offset decode.
    always_comb begin
        wd      = bus_wdata & {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
        wr_any  = bus_valid && bus_write && (bus_be != 4'b0000);
        hit_sel = (bus_addr == OFF_SELECT);
        hit_win = (bus_addr == OFF_WINDOW);
        win_wr  = wr_any && hit_win;
        tbl_wr  = win_wr && (kind == KIND_TBL) && idx_ok;
    end

    irq_redir_decode #(.NPINS(NPINS), .PIN_W(PIN_W)) dec_i (
        .sel    (sel_q),
        .kind   (kind),
        .idx_ok (idx_ok),
        .pin    (pin),
        .hi     (hi)
    );

    // One entry per pin, each fed its own half-write strobes.
    for (genvar i = 0; i < NPINS; i++) begin : g_ent
        logic pick;
        assign pick = tbl_wr && (pin == PIN_W'(i));
        irq_redir_entry ent_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (pick && !hi),
            .wr_hi    (pick && hi),
            .wdata    (wd),
            .rirr_set (rirr_set[i]),
            .q        (ent_q[i])
        );
        assign tbl_flat[i*64 +: 64] = ent_q[i];
    end

    // Selected entry and the mask/trigger values it holds after this write.
    always_comb begin
        cur      = ent_q[pin];
        new_mask = hi ? cur[F_MASK] : wd[F_MASK];
        new_trig = hi ? cur[F_TRIG] : wd[F_TRIG];
    end

    // Select and identification registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 8'h00;
            id_q  <= 4'h0;
        end else begin
            if (wr_any && hit_sel) begin
                sel_q <= wd[7:0];
            end
            if (win_wr && (kind == KIND_ID)) begin
                id_q <= wd[27:24];
            end
        end
    end

    // Notifications toward the interrupt engine, one cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_chg_valid <= 1'b0;
            mask_chg_pin   <= '0;
            mask_chg_value <= 1'b0;
            svc_valid      <= 1'b0;
            svc_pin        <= '0;
        end else begin
            mask_chg_valid <= tbl_wr && (new_mask != cur[F_MASK]);
            mask_chg_pin   <= pin;
            mask_chg_value <= new_mask;
            svc_valid      <= tbl_wr && new_trig && pin_req[pin];
            svc_pin        <= pin;
        end
    end

    // Read data for the addressed location.
    always_comb begin
        rd_next = 32'h0;
        if (hit_sel) begin
            rd_next = {24'h0, sel_q};
        end else if (hit_win) begin
            unique case (kind)
                KIND_ID, KIND_ARB: rd_next = {4'h0, id_q, 24'h0};
                KIND_VER:          rd_next = {8'h00, PIN_MAX, 8'h00, VERSION};
                KIND_TBL:          rd_next = idx_ok ? (hi ? cur[63:32] : cur[31:0]) : 32'h0;
                default:           rd_next = 32'h0;
            endcase
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= 32'h0;
        end else begin
            bus_rvalid <= bus_valid && !bus_write;
            bus_rdata  <= (bus_valid && !bus_write) ? rd_next : 32'h0;
        end
    end

endmodule

// File: rtl/irq_redir_regs_chk.sv
// Property checker for irq_redir_regs, attached by bind.
// Watches the bus, the notification pulses, the flat table and the
// select/ID registers.
module irq_redir_regs_chk #(
    parameter int NPINS = 24,
    parameter int PIN_W = $clog2(NPINS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [7:0]          bus_addr,
    input logic [3:0]          bus_be,
    input logic [31:0]         bus_wdata,
    input logic                bus_rvalid,
    input logic [NPINS*64-1:0] tbl_flat,
    input logic                mask_chg_valid,
    input logic [PIN_W-1:0]    mask_chg_pin,
    input logic                mask_chg_value,
    input logic                svc_valid,
    input logic [PIN_W-1:0]    svc_pin,
    input logic [7:0]          sel_q,
    input logic [3:0]          id_q
);
    localparam logic [PIN_W-1:0] PIN_LAST = PIN_W'(NPINS - 1);

    assert_rvalid_after_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && !bus_write));

    assert_select_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 8'h00 && bus_be == 4'hF)
        |=> (sel_q == $past(bus_wdata[7:0])));

    assert_mask_pin_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |-> (mask_chg_pin <= PIN_LAST));

    assert_mask_value_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |-> (tbl_flat[{mask_chg_pin, 6'd16}] == mask_chg_value));

    assert_mask_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |-> $past(bus_valid && bus_write));

    assert_service_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> ((svc_pin <= PIN_LAST) && tbl_flat[{svc_pin, 6'd15}]));

    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (sel_q == 8'h00 && id_q == 4'h0 && !mask_chg_valid && !svc_valid));

endmodule

bind irq_redir_regs irq_redir_regs_chk #(.NPINS(NPINS)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_valid      (bus_valid),
    .bus_write      (bus_write),
    .bus_addr       (bus_addr),
    .bus_be         (bus_be),
    .bus_wdata      (bus_wdata),
    .bus_rvalid     (bus_rvalid),
    .tbl_flat       (tbl_flat),
    .mask_chg_valid (mask_chg_valid),
    .mask_chg_pin   (mask_chg_pin),
    .mask_chg_value (mask_chg_value),
    .svc_valid      (svc_valid),
    .svc_pin        (svc_pin),
    .sel_q          (sel_q),
    .id_q           (id_q)
);

// File: tb/irq_redir_regs_tb_top.sv
// Scoreboard bench: the read task queues the expected word and a monitor
// compares it when bus_rvalid appears. Pulse checks follow each write.
module irq_redir_regs_tb_top;
    localparam int NPINS = 24;
    localparam int PIN_W = $clog2(NPINS);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_valid = 1'b0;
    logic                bus_ready;
    logic                bus_write = 1'b0;
    logic [7:0]          bus_addr = 8'h00;
    logic [3:0]          bus_be = 4'h0;
    logic [31:0]         bus_wdata = 32'h0;
    logic                bus_rvalid;
    logic [31:0]         bus_rdata;
    logic [NPINS-1:0]    pin_req = '0;
    logic [NPINS-1:0]    rirr_set = '0;
    logic [NPINS*64-1:0] tbl_flat;
    logic                mask_chg_valid;
    logic [PIN_W-1:0]    mask_chg_pin;
    logic                mask_chg_value;
    logic                svc_valid;
    logic [PIN_W-1:0]    svc_pin;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    irq_redir_regs #(.NPINS(NPINS)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .pin_req(pin_req), .rirr_set(rirr_set), .tbl_flat(tbl_flat),
        .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin),
        .mask_chg_value(mask_chg_value), .svc_valid(svc_valid), .svc_pin(svc_pin)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever read data is valid.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R13 unexpected rvalid", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic set_sel(input logic [7:0] s);
        bus_wr(8'h00, {24'h0, s}, 4'hF);
    endtask

    task automatic win_rd(input logic [7:0] s, input logic [31:0] exp, input string tag);
        set_sel(s);
        bus_rd(8'h10, exp, tag);
    endtask

    // Pulse outputs right after a write: {mask valid, pin, value, svc valid, pin}.
    task automatic chk_pulse(input string tag, input bit mv, input int mp, input bit mval,
                             input bit sv, input int sp);
        check({tag, " mask_chg_valid"}, 32'(mask_chg_valid), 32'(mv));
        if (mv) begin
            check({tag, " mask_chg_pin"}, 32'(mask_chg_pin), 32'(mp));
            check({tag, " mask_chg_value"}, 32'(mask_chg_value), 32'(mval));
        end
        check({tag, " svc_valid"}, 32'(svc_valid), 32'(sv));
        if (sv) check({tag, " svc_pin"}, 32'(svc_pin), 32'(sp));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R13 watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9 rvalid idle", 32'(bus_rvalid), 32'h0);
        check("R13 ready", 32'(bus_ready), 32'h1);
        bus_rd(8'h00, 32'h0, "R9 select reset");
        bus_rd(8'h10, 32'h0, "R9 id reset");
        win_rd(8'h10, 32'h0001_0000, "R9 entry0 low masked");
        win_rd(8'h3F, 32'h0, "R9 entry23 high zero");

        // R3 version, write ignored
        win_rd(8'h01, 32'h0017_0011, "R3 version");
        bus_wr(8'h10, 32'hFFFF_FFFF, 4'hF);
        chk_pulse("R3 no pulse", 0, 0, 0, 0, 0);
        bus_rd(8'h10, 32'h0017_0011, "R3 version after write");

        // R4 ID and arbitration alias
        set_sel(8'h00);
        bus_wr(8'h10, 32'h0A00_0000, 4'hF);
        bus_rd(8'h10, 32'h0A00_0000, "R4 id write");
        win_rd(8'h02, 32'h0A00_0000, "R4 arb alias");
        bus_wr(8'h10, 32'h0500_0000, 4'hF);
        win_rd(8'h00, 32'h0A00_0000, "R4 arb write ignored");

        // R1 select keeps low byte
        bus_wr(8'h00, 32'h1234_56AB, 4'hF);
        bus_rd(8'h00, 32'h0000_00AB, "R1 select low byte");

        // R2 R7 R8: pin 5 low half, level, unmasked, request pending
        pin_req[5] = 1'b1;
        set_sel(8'h1A);
        bus_wr(8'h10, 32'h0000_8031, 4'hF);
        chk_pulse("R7 R8 pin5 unmask level", 1, 5, 0, 1, 5);
        bus_rd(8'h10, 32'h0000_8031, "R2 pin5 low");
        set_sel(8'h1B);
        bus_wr(8'h10, 32'hFF00_0000, 4'hF);
        bus_rd(8'h10, 32'hFF00_0000, "R2 pin5 high");
        win_rd(8'h1A, 32'h0000_8031, "R5 high write keeps low");
        pin_req[5] = 1'b0;

        // R12 remote-IRR strobe, R5 low write clears it
        rirr_set[5] = 1'b1;
        @(negedge clk);
        rirr_set[5] = 1'b0;
        bus_rd(8'h10, 32'h0000_C031, "R12 remote-IRR set");
        set_sel(8'h1B);
        bus_wr(8'h10, 32'h1200_0000, 4'hF);
        win_rd(8'h1A, 32'h0000_C031, "R5 high write keeps remote-IRR");
        bus_wr(8'h10, 32'h0001_4031, 4'hF);
        chk_pulse("R7 pin5 remask", 1, 5, 1, 0, 0);
        bus_rd(8'h10, 32'h0001_0031, "R5 low write clears remote-IRR");
        win_rd(8'h1B, 32'h1200_0000, "R2 pin5 high kept");

        // R12 precedence: strobe and low write together
        set_sel(8'h1A);
        rirr_set[5] = 1'b1;
        bus_wr(8'h10, 32'h0001_0032, 4'hF);
        rirr_set[5] = 1'b0;
        bus_rd(8'h10, 32'h0001_0032, "R12 low write wins");

        // R6 out-of-range index
        set_sel(8'h40);
        bus_wr(8'h10, 32'hFFFF_FFFF, 4'hF);
        chk_pulse("R6 dropped write", 0, 0, 0, 0, 0);
        bus_rd(8'h10, 32'h0, "R6 read beyond table");
        win_rd(8'hFF, 32'h0, "R6 read top select");
        win_rd(8'h10, 32'h0001_0000, "R6 entry0 untouched");

        // R10 decode of offsets
        bus_rd(8'h04, 32'h0, "R10 misaligned read");
        bus_wr(8'h08, 32'h0000_0077, 4'hF);
        bus_wr(8'h20, 32'h0000_0055, 4'hF);
        bus_rd(8'h00, 32'h0000_0010, "R10 ignored writes");
        bus_rd(8'h20, 32'h0, "R10 unknown offset");
        bus_wr(8'h14, 32'h0000_0000, 4'hF);
        chk_pulse("R10 misaligned window write", 0, 0, 0, 0, 0);
        win_rd(8'h10, 32'h0001_0000, "R10 entry0 after misaligned");

        // R11 narrow writes
        bus_wr(8'h00, 32'hFFFF_FF5C, 4'b0001);
        bus_rd(8'h00, 32'h0000_005C, "R11 byte select");
        bus_wr(8'h00, 32'h0000_0033, 4'b0000);
        bus_rd(8'h00, 32'h0000_005C, "R11 no lanes");
        set_sel(8'h16);
        bus_wr(8'h10, 32'hFFFF_0042, 4'b0011);
        chk_pulse("R11 R7 pin3 unmask by zero-ext", 1, 3, 0, 0, 0);
        bus_rd(8'h10, 32'h0000_0042, "R11 pin3 halfword");
        set_sel(8'h00);
        bus_wr(8'h10, 32'h0F00_0000, 4'b0011);
        bus_rd(8'h10, 32'h0, "R11 id zero-extended");

        // R8 service conditions on pin 7
        set_sel(8'h1E);
        bus_wr(8'h10, 32'h0000_8040, 4'hF);
        chk_pulse("R8 level without request", 1, 7, 0, 0, 0);
        pin_req[7] = 1'b1;
        set_sel(8'h1F);
        bus_wr(8'h10, 32'h0100_0000, 4'hF);
        chk_pulse("R8 high write keeps level", 0, 0, 0, 1, 7);
        set_sel(8'h1E);
        bus_wr(8'h10, 32'h0000_0040, 4'hF);
        chk_pulse("R8 edge no service", 0, 0, 0, 0, 0);
        pin_req[7] = 1'b0;

        // R13 write gives no response
        @(negedge clk);
        check("R13 no rvalid after write", 32'(bus_rvalid), 32'h0);
        repeat (2) @(negedge clk);
        check("R13 scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        finish_run();
    end

endmodule